// File: doc/BRIEF.md
# Sample Phase Window Tuner

This block finds a good sampling phase for a receive clock. On a start pulse it walks a phase index across `N_STEPS` evenly spaced positions around one clock period. For each position it offers the phase in degrees on a valid/ready output, then raises a test request to an external checker and waits for a pass or fail answer. Passing positions are grouped into contiguous runs. The sweep is treated as a ring, so a run that touches the end can join the run that starts at position zero.

After the sweep the block picks the longest run and applies the phase at its centre. If every position passed, it applies a configured default phase and raises an all-pass flag. If nothing passed, it raises an error and applies no phase. A failing position makes the sweep jump ahead by roughly twenty degrees, because probing near a bad phase is slow. The final position is always probed.

Top module: `phase_window_tuner`

## Requirements
- R1: Step index i is offered as the phase ceil(i*360/N_STEPS) degrees on `phase_deg`. `phase_vld` and `phase_deg` stay stable until `phase_rdy` is sampled high.
- R2: After a pass the index rises by one. After a fail at any step other than N_STEPS-1, it rises by ceil(20*N_STEPS/360), clamped to N_STEPS-1. A fail at N_STEPS-1 ends the sweep, so step N_STEPS-1 is always probed.
- R3: `test_req` stays high until `test_resp_vld` is sampled or `RESP_TIMEOUT` cycles pass. A timeout counts as a fail.
- R4: A pass that follows a fail, or the first step, opens a new run. Each pass moves the end of the current run to that step. At most N_STEPS/2+1 runs are kept.
- R5: If more than one run exists and both step 0 and the last probed step passed, the first run takes the start of the last run and the last run is dropped.
- R6: Run length is end-start+1, plus N_STEPS when that value is negative. The earliest run with the strictly largest length wins.
- R7: The winning step is (start + length/2) mod N_STEPS. Its phase in degrees is offered through the phase handshake and held on `final_deg`.
- R8: If no step passes, `err` is set, no final phase handshake occurs, and `final_deg` keeps its previous value.
- R9: If one run spans step 0 through N_STEPS-1, `DEFAULT_DEG` is applied and `all_pass` is set.
- R10: After reset all outputs are low or zero. `start` during a search is ignored. `done` is high for exactly one cycle per search, and `err` and `all_pass` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (ignored while busy) |
| phase_deg | output | 9 | Phase to apply, in degrees |
| phase_vld | output | 1 | Phase request valid |
| phase_rdy | input | 1 | Phase has been applied |
| test_req | output | 1 | Ask the checker to probe the current phase |
| test_resp_vld | input | 1 | Checker answer valid |
| test_pass | input | 1 | Checker answer: 1 pass, 0 fail |
| done | output | 1 | One-cycle search-complete pulse |
| err | output | 1 | No passing phase was found |
| all_pass | output | 1 | Every probed phase passed |
| final_deg | output | 9 | Last applied final phase, in degrees |

## Verification
The hardest situations to reach from the ports are the ring merge and the timeout fail. The merge needs passes at both ends of the sweep, with the jump after a fail landing inside the upper run. The timeout needs a checker that stays silent on one chosen step while answering all the others. The bench checker looks up each step's pass pattern by the phase it was handed, and it can mute individual steps. Patterns are chosen so that the skipped positions, the clamp to the last step, a tie between equal runs and a merged run that wraps past step zero each change the expected phase list.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int DEG_W = 9;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETPH,
        S_TEST,
        S_EVAL,
        S_MERGE,
        S_CHKALL,
        S_SCAN,
        S_APPLY,
        S_FINISH
    } tune_st_e;

    typedef struct packed {
        logic err;
        logic all_pass;
    } tune_flags_t;

    // ceil(step * 360 / nsteps)
    function automatic logic [DEG_W-1:0] step_to_deg(input int unsigned step,
                                                     input int unsigned nsteps);
        int unsigned t;
        t = (step * 32'd360 + nsteps - 32'd1) / nsteps;
        return t[DEG_W-1:0];
    endfunction

    // ceil(20 * nsteps / 360)
    function automatic int unsigned skip_len(input int unsigned nsteps);
        return (32'd20 * nsteps + 32'd359) / 32'd360;
    endfunction

endpackage

// File: rtl/pt_wait_timer.sv
module pt_wait_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) cnt_q <= '0;
        else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = en && (cnt_q == LIM_V);

    // R3
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en && expired |=> !en || expired);
endmodule

// File: rtl/pt_span_store.sv
module pt_span_store #(
    parameter int IW   = 9,
    parameter int MAXR = 181
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           open_en,
    input  logic                           ext_en,
    input  logic                           merge_en,
    input  logic [IW-1:0]                  pos,
    input  logic [$clog2(MAXR+1)-1:0]      rd_sel,
    output logic [IW-1:0]                  rd_first,
    output logic [IW-1:0]                  rd_last,
    output logic [$clog2(MAXR+1)-1:0]      cnt
);
    localparam int CW    = $clog2(MAXR + 1);
    localparam int DEPTH = 1 << CW;
    localparam logic [CW-1:0] MAX_V = CW'(MAXR);

    logic [IW-1:0] first_a [DEPTH];
    logic [IW-1:0] last_a  [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] top_i;

    assign top_i = cnt_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (open_en && cnt_q != MAX_V) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (merge_en && cnt_q > 1) begin
            cnt_q <= top_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clr) begin
            if (open_en && cnt_q != MAX_V) begin
                first_a[cnt_q] <= pos;
                last_a[cnt_q]  <= pos;
            end else if (ext_en && cnt_q != '0) begin
                last_a[top_i] <= pos;
            end else if (merge_en && cnt_q > 1) begin
                first_a[0] <= first_a[top_i];
            end
        end
    end

    assign rd_first = first_a[rd_sel];
    assign rd_last  = last_a[rd_sel];
    assign cnt      = cnt_q;

    // R4
    span_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= MAX_V);
    // R5
    merge_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        merge_en && !clr && cnt_q > 1 |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pt_best_span.sv
module pt_best_span #(
    parameter int N_STEPS = 360,
    parameter int IW      = 9,
    parameter int CW      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [CW-1:0] cnt,
    input  logic [IW-1:0] rd_first,
    input  logic [IW-1:0] rd_last,
    output logic [CW-1:0] rd_sel,
    output logic          fin,
    output logic [IW-1:0] best_step
);
    localparam int LW = IW + 1;
    localparam logic [LW-1:0] NV = LW'(N_STEPS);

    logic [CW-1:0] k_q;
    logic          act_q, fin_q;
    logic [LW-1:0] best_len_q;
    logic [IW-1:0] best_first_q;
    logic [LW-1:0] lw, fw, len, sum, step;

    always_comb begin
        lw  = {1'b0, rd_last} + 1'b1;
        fw  = {1'b0, rd_first};
        len = (lw >= fw) ? (lw - fw) : (lw + NV - fw);
        sum = {1'b0, best_first_q} + (best_len_q >> 1);
        step = (sum >= NV) ? (sum - NV) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q          <= '0;
            act_q        <= 1'b0;
            fin_q        <= 1'b0;
            best_len_q   <= '0;
            best_first_q <= '0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                k_q        <= '0;
                act_q      <= 1'b1;
                best_len_q <= '0;
            end else if (act_q) begin
                if (len > best_len_q) begin
                    best_len_q   <= len;
                    best_first_q <= rd_first;
                end
                if (k_q == cnt - 1'b1) begin
                    act_q <= 1'b0;
                    fin_q <= 1'b1;
                end else begin
                    k_q <= k_q + 1'b1;
                end
            end
        end
    end

    assign rd_sel    = k_q;
    assign fin       = fin_q;
    assign best_step = step[IW-1:0];

    // R6
    winner_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> best_len_q != '0);
    // R7
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> {1'b0, best_step} < NV);
endmodule

// File: rtl/phase_window_tuner.sv
module phase_window_tuner
    import pt_pkg::*;
#(
    parameter int N_STEPS      = 360,
    parameter int DEFAULT_DEG  = 0,
    parameter int RESP_TIMEOUT = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [DEG_W-1:0] phase_deg,
    output logic             phase_vld,
    input  logic             phase_rdy,
    output logic             test_req,
    input  logic             test_resp_vld,
    input  logic             test_pass,
    output logic             done,
    output logic             err,
    output logic             all_pass,
    output logic [DEG_W-1:0] final_deg
);
    localparam int SKIP = skip_len(N_STEPS);
    localparam int IW   = $clog2(N_STEPS + SKIP + 1);
    localparam int MAXR = N_STEPS / 2 + 1;
    localparam int CW   = $clog2(MAXR + 1);
    localparam logic [IW-1:0] LAST_I = IW'(N_STEPS - 1);
    localparam logic [IW-1:0] END_I  = IW'(N_STEPS);
    localparam logic [IW-1:0] SKIP_I = IW'(SKIP);

    tune_st_e         st_q;
    logic [IW-1:0]    idx_q, idx_nx, jump;
    logic             v_q, prev_q, first_q;
    tune_flags_t      flags_q;
    logic [DEG_W-1:0] final_q;
    logic             tmo;
    logic [IW-1:0]    rd_first, rd_last, best_step;
    logic [CW-1:0]    rd_sel, pick_sel, cnt;
    logic             pick_go, pick_fin, full;
    logic             clr, open_en, ext_en, merge_en;

    pt_wait_timer #(.LIMIT(RESP_TIMEOUT)) u_tmr (
        .clk(clk), .rst(rst), .en(st_q == S_TEST), .expired(tmo)
    );

    pt_span_store #(.IW(IW), .MAXR(MAXR)) u_store (
        .clk(clk), .rst(rst), .clr(clr), .open_en(open_en), .ext_en(ext_en),
        .merge_en(merge_en), .pos(idx_q), .rd_sel(rd_sel),
        .rd_first(rd_first), .rd_last(rd_last), .cnt(cnt)
    );

    pt_best_span #(.N_STEPS(N_STEPS), .IW(IW), .CW(CW)) u_pick (
        .clk(clk), .rst(rst), .go(pick_go), .cnt(cnt),
        .rd_first(rd_first), .rd_last(rd_last), .rd_sel(pick_sel),
        .fin(pick_fin), .best_step(best_step)
    );

    always_comb begin
        jump = idx_q + SKIP_I;
        if (v_q || idx_q == LAST_I) idx_nx = idx_q + 1'b1;
        else if (jump > LAST_I)     idx_nx = LAST_I;
        else                        idx_nx = jump;
    end

    assign clr      = (st_q == S_IDLE) && start;
    assign open_en  = (st_q == S_EVAL) && v_q && !prev_q;
    assign ext_en   = (st_q == S_EVAL) && v_q && prev_q;
    assign merge_en = (st_q == S_MERGE) && (cnt > 1) && first_q && prev_q;
    assign rd_sel   = (st_q == S_SCAN) ? pick_sel : '0;
    assign full     = (rd_first == '0) && (rd_last == LAST_I);
    assign pick_go  = (st_q == S_CHKALL) && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            idx_q   <= '0;
            v_q     <= 1'b0;
            prev_q  <= 1'b0;
            first_q <= 1'b0;
            flags_q <= '0;
            final_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    idx_q   <= '0;
                    prev_q  <= 1'b0;
                    flags_q <= '0;
                    st_q    <= S_SETPH;
                end
                S_SETPH: if (phase_rdy) st_q <= S_TEST;
                S_TEST: begin
                    if (test_resp_vld) begin
                        v_q  <= test_pass;
                        st_q <= S_EVAL;
                    end else if (tmo) begin
                        v_q  <= 1'b0;
                        st_q <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (idx_q == '0) first_q <= v_q;
                    prev_q <= v_q;
                    idx_q  <= idx_nx;
                    st_q   <= (idx_nx == END_I) ? S_MERGE : S_SETPH;
                end
                S_MERGE: begin
                    if (cnt == '0) begin
                        flags_q.err <= 1'b1;
                        st_q        <= S_FINISH;
                    end else begin
                        st_q <= S_CHKALL;
                    end
                end
                S_CHKALL: begin
                    if (full) begin
                        final_q          <= DEG_W'(DEFAULT_DEG);
                        flags_q.all_pass <= 1'b1;
                        st_q             <= S_APPLY;
                    end else begin
                        st_q <= S_SCAN;
                    end
                end
                S_SCAN: if (pick_fin) begin
                    final_q <= step_to_deg(32'(best_step), N_STEPS);
                    st_q    <= S_APPLY;
                end
                S_APPLY: if (phase_rdy) st_q <= S_FINISH;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign phase_vld = (st_q == S_SETPH) || (st_q == S_APPLY);
    assign phase_deg = (st_q == S_APPLY) ? final_q : step_to_deg(32'(idx_q), N_STEPS);
    assign test_req  = (st_q == S_TEST);
    assign done      = (st_q == S_FINISH);
    assign err       = flags_q.err;
    assign all_pass  = flags_q.all_pass;
    assign final_deg = final_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R1
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        phase_vld && !phase_rdy |=> phase_vld && $stable(phase_deg));
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        test_req && !test_resp_vld && !tmo |=> test_req);
    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !(err && all_pass));
    // R2
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        phase_vld && st_q == S_SETPH |-> idx_q <= LAST_I);
endmodule

// File: tb/sim_phase_window_tuner.sv
module sim_phase_window_tuner;
    localparam int N    = 48;
    localparam int DEF  = 90;
    localparam int TMO  = 16;
    localparam int SKIP = (20 * N + 359) / 360;

    typedef struct {
        bit    err;
        bit    allp;
        int    ph;
        string tag;
    } res_t;

    logic clk = 0, rst = 1, start = 0;
    logic [8:0] phase_deg, final_deg;
    logic phase_vld, phase_rdy = 0, test_req, test_resp_vld = 0, test_pass = 0;
    logic done, err, all_pass;

    int n_run = 0, n_fail = 0;
    int exp_ph[$];
    res_t exp_res[$];
    bit [N-1:0] pat, sil;
    int cur_step = 0;
    int last_final = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    phase_window_tuner #(.N_STEPS(N), .DEFAULT_DEG(DEF), .RESP_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst(rst), .start(start), .phase_deg(phase_deg),
        .phase_vld(phase_vld), .phase_rdy(phase_rdy), .test_req(test_req),
        .test_resp_vld(test_resp_vld), .test_pass(test_pass), .done(done),
        .err(err), .all_pass(all_pass), .final_deg(final_deg)
    );

    function automatic int deg_of(input int j);
        return (j * 360 + N - 1) / N;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // phase handshake monitor (R1 R2 R7)
    initial forever begin
        @(negedge clk);
        if (phase_vld && !phase_rdy) begin
            phase_rdy = 1;
            if (exp_ph.size() == 0) begin
                check(0, "R10 unexpected phase", int'(phase_deg), -1);
            end else begin
                int e;
                e = exp_ph.pop_front();
                check(int'(phase_deg) == e, "R1 R2 phase order", int'(phase_deg), e);
            end
            for (int j = 0; j < N; j++) if (deg_of(j) == int'(phase_deg)) cur_step = j;
        end else begin
            phase_rdy = 0;
        end
    end

    // checker model (R3: muted steps never answer)
    initial forever begin
        @(negedge clk);
        if (test_req) begin
            if (!sil[cur_step]) begin
                @(negedge clk);
                test_resp_vld = 1;
                test_pass = pat[cur_step];
                @(negedge clk);
                test_resp_vld = 0;
            end
            while (test_req) @(negedge clk);
        end
    end

    // result monitor
    initial forever begin
        @(negedge clk);
        if (done) begin
            if (exp_res.size() == 0) begin
                check(0, "R10 unexpected done", 1, 0);
            end else begin
                res_t r;
                r = exp_res.pop_front();
                check(err == r.err, {r.tag, " err"}, int'(err), int'(r.err));
                check(all_pass == r.allp, {r.tag, " all_pass"}, int'(all_pass), int'(r.allp));
                check(int'(final_deg) == r.ph, {r.tag, " final_deg"}, int'(final_deg), r.ph);
                check(exp_ph.size() == 0, "R8 R7 leftover phases", exp_ph.size(), 0);
            end
        end
    end

    // watchdog
    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        check(0, "watchdog", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // driver: computes expectations from the requirements and runs one search
    task automatic run_case(input bit [N-1:0] p, input bit [N-1:0] s,
                            input string tag, input bit poke);
        int i, cnt, rs[$], re[$], best, bl, mid, len;
        bit v, prev, first;
        res_t r;
        pat = p; sil = s;
        i = 0; prev = 0; first = 0; v = 0;
        while (i < N) begin
            exp_ph.push_back(deg_of(i));
            v = p[i] && !s[i];
            if (i == 0) first = v;
            if (v) begin
                if (!prev) begin rs.push_back(i); re.push_back(i); end
                re[re.size()-1] = i;
                i++;
            end else if (i == N - 1) begin
                i++;
            end else begin
                i += SKIP;
                if (i >= N) i = N - 1;
            end
            prev = v;
        end
        cnt = rs.size();
        r.tag = tag; r.err = 0; r.allp = 0;
        if (cnt == 0) begin
            r.err = 1; r.ph = last_final;
        end else begin
            if (cnt > 1 && first && v) begin
                rs[0] = rs[cnt-1];
                cnt--;
            end
            if (rs[0] == 0 && re[0] == N - 1) begin
                r.allp = 1; r.ph = DEF;
            end else begin
                bl = 0; best = 0;
                for (int k = 0; k < cnt; k++) begin
                    len = re[k] - rs[k] + 1;
                    if (len < 0) len += N;
                    if (len > bl) begin bl = len; best = k; end
                end
                mid = (rs[best] + bl / 2) % N;
                r.ph = deg_of(mid);
            end
            exp_ph.push_back(r.ph);
            last_final = r.ph;
        end
        exp_res.push_back(r);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        begin
            int g;
            g = 0;
            while (exp_res.size() != 0 && g < 20000) begin @(negedge clk); g++; end
            check(g < 20000, {tag, " search finished"}, g, 0);
        end
        repeat (10) @(negedge clk);
    endtask

    function automatic bit [N-1:0] span(input int a, input int b);
        bit [N-1:0] m;
        m = '0;
        for (int j = a; j <= b; j++) m[j] = 1'b1;
        return m;
    endfunction

    initial begin
        pat = '0; sil = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check(!done && !err && !all_pass, "R10 reset flags", int'(done | err | all_pass), 0);
        check(!phase_vld && !test_req, "R10 reset requests", int'(phase_vld | test_req), 0);
        check(final_deg == 0, "R10 reset final_deg", int'(final_deg), 0);

        run_case(span(12, 26), '0, "R4 R7 single run", 0);
        run_case(span(0, 9) | span(40, 47), '0, "R5 wrap merge", 0);
        run_case(span(3, 8) | span(24, 29), '0, "R6 tie first wins", 0);
        run_case(span(2, 4) | span(20, 30), '0, "R6 longer later", 0);
        run_case(span(47, 47), '0, "R2 last step clamp", 0);
        run_case('0, '0, "R8 all fail", 0);
        run_case('1, '0, "R9 all pass", 0);
        run_case('1, span(10, 10), "R3 timeout fail", 0);
        run_case(span(12, 26), '0, "R10 start while busy", 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule